// File: doc/BRIEF.md
# UART Transmit FIFO with Trigger-Level Interrupt

This block buffers bytes between a host and a UART transmit shift register. The host pushes bytes on a write port. The shifter pulls them in arrival order through a ready/valid drain port. A control-register write port carries three things: the FIFO enable, a one-shot FIFO reset request, and a 2-bit threshold select. The block reports the current fill level, empty and full flags, a sticky overflow flag, the active threshold, and a transmit interrupt request.

There are two ways the interrupt can fire. If the last reload pushed the fill level above the threshold, the interrupt fires when draining takes the level below the threshold. If the reload never got above the threshold, the interrupt waits until the FIFO runs dry. When the FIFO is disabled, the block behaves as a one-byte holding register and interrupts when that byte leaves.

Top module: `uart_txfifo_irq`

## Requirements
- R1: After reset the level is 0, `empty` is 1, `full`, `txIrq` and `overflow` are 0, the FIFO is disabled and `trigLevel` reads 16.
- R2: With the FIFO enabled, bytes leave the drain port in the order they were accepted. `drainValid` is 1 exactly when the level is non-zero. The level rises by one per accepted write and falls by one per drain handshake, and it is unchanged when both happen in the same cycle.
- R3: With the FIFO enabled, `full` is 1 at 32 entries. A write while full is dropped, leaves the level unchanged and sets `overflow`. `overflow` stays 1 until the FIFO is cleared.
- R4: With the FIFO disabled, capacity is one byte: `full` is 1 at level 1, and a second write is dropped and sets `overflow`.
- R5: A control write with enable=1 and reset=1 empties the FIFO (level 0, pointers cleared) and clears `overflow` in the next cycle. The reset bit is not stored, so later writes are accepted. A control write with enable=0 and reset=1 to a FIFO that is already disabled leaves the level and `overflow` unchanged.
- R6: The threshold select maps 00→16, 01→8, 10→24 and 11→30, shown on `trigLevel`. The select is updated only by control writes made while `enhancedEn`=1. Otherwise the stored select is kept.
- R7: If the level has been above the threshold since the FIFO was last empty or cleared, a drain that takes the level from at least the threshold to below it sets `txIrq` in the next cycle.
- R8: If the level has not been above the threshold since the FIFO was last empty or cleared, `txIrq` is not set on the threshold crossing. It is set when a drain takes the level to 0. A fill of exactly the threshold counts as not above it.
- R9: Any host write strobe or `irqAck` clears `txIrq` in the next cycle unless a new event sets it in that same cycle. After an acknowledge, `txIrq` stays 0 until a new crossing or qualifying empty event.
- R10: With the FIFO disabled, draining the held byte sets `txIrq`.
- R11: A control write that changes the enable bit empties the FIFO and clears `overflow` and `txIrq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Host write strobe |
| wrData | input | 8 | Host write byte |
| drainValid | output | 1 | A byte is available to the shifter |
| drainData | output | 8 | Oldest byte in the FIFO |
| drainReady | input | 1 | Shifter accepts the byte this cycle |
| cfgWrite | input | 1 | Control-register write strobe |
| cfgFifoEn | input | 1 | FIFO enable value written |
| cfgReset | input | 1 | FIFO reset request (one-shot) |
| cfgTrigSel | input | 2 | Threshold select value written |
| enhancedEn | input | 1 | Allows the threshold select to be written |
| irqAck | input | 1 | Host read of interrupt status, clears the request |
| level | output | 6 | Current fill level |
| empty | output | 1 | Level is zero |
| full | output | 1 | Level has reached capacity |
| overflow | output | 1 | Sticky dropped-write flag |
| trigLevel | output | 6 | Active threshold in entries |
| txIrq | output | 1 | Transmit interrupt request |

## Verification
The bench loads the FIFO to exactly the threshold and drains it. A design that treats "at the threshold" as "above it" would interrupt at the crossing instead of waiting for empty. It also loads the FIFO past the threshold, acknowledges the crossing interrupt and drains to empty. A design that did not track the last reload would raise a second, spurious interrupt there. Further cases check that a write at 32 entries is dropped (an off-by-one capacity would accept it or corrupt the order), that a reset request with enable low does nothing, and that threshold writes with the enhanced enable low are ignored.

// File: rtl/uart_txfifo_pkg.sv
package uart_txfifo_pkg;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifoCtlS;

  // threshold in entries for a 2-bit select, scaled from the depth
  function automatic int unsigned trigFor(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'b00:   return depth / 2;
      2'b01:   return depth / 4;
      2'b10:   return (depth * 3) / 4;
      default: return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/txfifo_datapath.sv
module txfifo_datapath
  import uart_txfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PTRW = $clog2(DEPTH),
  localparam int unsigned LVLW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoCtlS          ctl,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic [LVLW-1:0]  count
);

  localparam logic [PTRW-1:0] LAST = PTRW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTRW-1:0]  wrPtr;
  logic [PTRW-1:0]  rdPtr;

  always_ff @(posedge clk) begin
    if (ctl.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (ctl.pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      count <= count + LVLW'(ctl.push) - LVLW'(ctl.pop);
    end
  end

  assign rdData = mem[rdPtr];

endmodule

// File: rtl/txfifo_ctrl.sv
module txfifo_ctrl
  import uart_txfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned LVLW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrValid,
  input  logic            drainReady,
  input  logic            cfgWrite,
  input  logic            cfgFifoEn,
  input  logic            cfgReset,
  input  logic [1:0]      cfgTrigSel,
  input  logic            enhancedEn,
  input  logic            irqAck,
  input  logic [LVLW-1:0] count,
  output fifoCtlS         ctl,
  output logic            drainValid,
  output logic            empty,
  output logic            full,
  output logic            overflow,
  output logic [LVLW-1:0] trigLevel,
  output logic            txIrq
);

  logic            fifoEn;
  logic [1:0]      trigSel;
  logic            aboveSeen;
  logic [LVLW-1:0] capacity;
  logic [LVLW-1:0] nextCount;
  logic            crossEvt;
  logic            emptyEvt;

  assign capacity  = fifoEn ? LVLW'(DEPTH) : LVLW'(1);
  assign trigLevel = LVLW'(trigFor(trigSel, DEPTH));
  assign empty     = (count == '0);
  assign full      = (count >= capacity);
  assign drainValid = !empty;

  always_comb begin
    ctl.clear = cfgWrite && ((cfgFifoEn && cfgReset) || (cfgFifoEn != fifoEn));
    ctl.push  = wrValid && !full && !ctl.clear;
    ctl.pop   = drainValid && drainReady && !ctl.clear;
  end

  assign nextCount = count + LVLW'(ctl.push) - LVLW'(ctl.pop);
  assign crossEvt  = fifoEn && aboveSeen && (count >= trigLevel) && (nextCount < trigLevel);
  assign emptyEvt  = !aboveSeen && (count != '0) && (nextCount == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoEn  <= 1'b0;
      trigSel <= 2'b00;
    end else if (cfgWrite) begin
      fifoEn <= cfgFifoEn;
      if (enhancedEn) trigSel <= cfgTrigSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      aboveSeen <= 1'b0;
      txIrq     <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (wrValid && full) overflow <= 1'b1;
      if (nextCount == '0)
        aboveSeen <= 1'b0;
      else if (fifoEn && (nextCount > trigLevel))
        aboveSeen <= 1'b1;
      if (crossEvt || emptyEvt)
        txIrq <= 1'b1;
      else if (wrValid || irqAck)
        txIrq <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_txfifo_irq.sv
module uart_txfifo_irq
  import uart_txfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned LVLW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [WIDTH-1:0] wrData,
  output logic             drainValid,
  output logic [WIDTH-1:0] drainData,
  input  logic             drainReady,
  input  logic             cfgWrite,
  input  logic             cfgFifoEn,
  input  logic             cfgReset,
  input  logic [1:0]       cfgTrigSel,
  input  logic             enhancedEn,
  input  logic             irqAck,
  output logic [LVLW-1:0]  level,
  output logic             empty,
  output logic             full,
  output logic             overflow,
  output logic [LVLW-1:0]  trigLevel,
  output logic             txIrq
);

  fifoCtlS ctl;

  txfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .drainReady(drainReady),
    .cfgWrite(cfgWrite), .cfgFifoEn(cfgFifoEn), .cfgReset(cfgReset),
    .cfgTrigSel(cfgTrigSel), .enhancedEn(enhancedEn), .irqAck(irqAck),
    .count(level), .ctl(ctl), .drainValid(drainValid), .empty(empty),
    .full(full), .overflow(overflow), .trigLevel(trigLevel), .txIrq(txIrq)
  );

  txfifo_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .rdData(drainData), .count(level)
  );

endmodule

// File: rtl/txfifo_checker.sv
module txfifo_checker #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned LVLW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            wrValid,
  input logic            drainValid,
  input logic            drainReady,
  input logic            cfgWrite,
  input logic            cfgFifoEn,
  input logic            cfgReset,
  input logic            enhancedEn,
  input logic            irqAck,
  input logic [LVLW-1:0] level,
  input logic            full,
  input logic            overflow,
  input logic [LVLW-1:0] trigLevel,
  input logic            txIrq
);

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVLW'(DEPTH));

  assert_drain_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    drainValid == (level != '0));

  assert_pop_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (drainValid && drainReady && !wrValid && !cfgWrite) |=> level == $past(level) - 1'b1);

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (full && wrValid && !drainReady && !cfgWrite) |=> (level == $past(level)) && overflow);

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !cfgWrite) |=> overflow);

  assert_fifo_reset_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && cfgFifoEn && cfgReset) |=> (level == '0) && !overflow);

  assert_trig_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && !enhancedEn) |=> $stable(trigLevel));

  assert_irq_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    (txIrq && irqAck && !drainReady && !cfgWrite) |=> !txIrq);

endmodule

bind uart_txfifo_irq txfifo_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .drainValid(drainValid),
  .drainReady(drainReady), .cfgWrite(cfgWrite), .cfgFifoEn(cfgFifoEn),
  .cfgReset(cfgReset), .enhancedEn(enhancedEn), .irqAck(irqAck),
  .level(level), .full(full), .overflow(overflow), .trigLevel(trigLevel),
  .txIrq(txIrq)
);

// File: tb/uart_txfifo_irq_tb.sv
module uart_txfifo_irq_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic       drainValid;
  logic [7:0] drainData;
  logic       drainReady = 1'b0;
  logic       cfgWrite = 1'b0;
  logic       cfgFifoEn = 1'b0;
  logic       cfgReset = 1'b0;
  logic [1:0] cfgTrigSel = 2'b00;
  logic       enhancedEn = 1'b0;
  logic       irqAck = 1'b0;
  logic [5:0] level;
  logic       empty;
  logic       full;
  logic       overflow;
  logic [5:0] trigLevel;
  logic       txIrq;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  uart_txfifo_irq u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .drainValid(drainValid), .drainData(drainData), .drainReady(drainReady),
    .cfgWrite(cfgWrite), .cfgFifoEn(cfgFifoEn), .cfgReset(cfgReset),
    .cfgTrigSel(cfgTrigSel), .enhancedEn(enhancedEn), .irqAck(irqAck),
    .level(level), .empty(empty), .full(full), .overflow(overflow),
    .trigLevel(trigLevel), .txIrq(txIrq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    wrValid = 1'b1; wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic popOne(output logic [7:0] d);
    d = drainData;
    drainReady = 1'b1;
    @(negedge clk);
    drainReady = 1'b0;
  endtask

  task automatic cfg(input logic en, input logic rst, input logic [1:0] sel, input logic enh);
    cfgWrite = 1'b1; cfgFifoEn = en; cfgReset = rst; cfgTrigSel = sel; enhancedEn = enh;
    @(negedge clk);
    cfgWrite = 1'b0; cfgReset = 1'b0; enhancedEn = 1'b0;
  endtask

  task automatic ack();
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  task automatic testReset();
    check("R1", "level", level, 0);
    check("R1", "empty", empty, 1);
    check("R1", "full", full, 0);
    check("R1", "txIrq", txIrq, 0);
    check("R1", "overflow", overflow, 0);
    check("R1", "trigLevel", trigLevel, 16);
  endtask

  task automatic testDisabled();
    logic [7:0] d;
    push(8'h5A);
    check("R4", "level after one write", level, 1);
    check("R4", "full at one", full, 1);
    push(8'hC3);
    check("R4", "level after dropped write", level, 1);
    check("R4", "overflow", overflow, 1);
    cfg(1'b0, 1'b1, 2'b00, 1'b0);
    check("R5", "reset with enable low keeps level", level, 1);
    check("R5", "reset with enable low keeps overflow", overflow, 1);
    popOne(d);
    check("R4", "held byte", d, 8'h5A);
    check("R10", "irq after holding byte drained", txIrq, 1);
  endtask

  task automatic testEnableChange();
    push(8'h11);
    cfg(1'b1, 1'b0, 2'b00, 1'b0);
    check("R11", "level after enable change", level, 0);
    check("R11", "overflow after enable change", overflow, 0);
    check("R11", "irq after enable change", txIrq, 0);
  endtask

  task automatic testOrder();
    logic [7:0] d;
    for (int i = 0; i < 5; i++) push(8'(8'h20 + i));
    check("R2", "level after 5 writes", level, 5);
    for (int i = 0; i < 3; i++) begin
      popOne(d);
      check("R2", "drain order", d, 8'h20 + i);
    end
    check("R2", "level after 3 drains", level, 2);
    wrValid = 1'b1; wrData = 8'h30; drainReady = 1'b1;
    @(negedge clk);
    wrValid = 1'b0; drainReady = 1'b0;
    check("R2", "level after push and pop together", level, 2);
    popOne(d);
    check("R2", "order after concurrent", d, 8'h24);
    popOne(d);
    check("R2", "order of concurrent byte", d, 8'h30);
    check("R2", "drainValid when empty", drainValid, 0);
  endtask

  task automatic testFullOverflow();
    logic [7:0] d;
    int bad = 0;
    for (int i = 0; i < 32; i++) push(8'(i * 3 + 1));
    check("R3", "level at capacity", level, 32);
    check("R3", "full flag", full, 1);
    push(8'hEE);
    check("R3", "level after dropped write", level, 32);
    check("R3", "overflow set", overflow, 1);
    for (int i = 0; i < 32; i++) begin
      popOne(d);
      if (d != 8'(i * 3 + 1)) bad++;
    end
    check("R3", "mismatched bytes after overflow", bad, 0);
    check("R3", "overflow still sticky", overflow, 1);
  endtask

  task automatic testFifoReset();
    push(8'h01); push(8'h02); push(8'h03);
    cfg(1'b1, 1'b1, 2'b00, 1'b0);
    check("R5", "level after reset", level, 0);
    check("R5", "empty after reset", empty, 1);
    check("R5", "overflow after reset", overflow, 0);
    push(8'h44);
    check("R5", "write accepted after reset", level, 1);
    check("R5", "data after reset", drainData, 8'h44);
    cfg(1'b1, 1'b1, 2'b00, 1'b0);
  endtask

  task automatic testTrigMap();
    cfg(1'b1, 1'b0, 2'b01, 1'b1);
    check("R6", "sel 01", trigLevel, 8);
    cfg(1'b1, 1'b0, 2'b10, 1'b1);
    check("R6", "sel 10", trigLevel, 24);
    cfg(1'b1, 1'b0, 2'b11, 1'b1);
    check("R6", "sel 11", trigLevel, 30);
    cfg(1'b1, 1'b0, 2'b00, 1'b1);
    check("R6", "sel 00", trigLevel, 16);
    cfg(1'b1, 1'b0, 2'b11, 1'b0);
    check("R6", "locked write ignored", trigLevel, 16);
    cfg(1'b1, 1'b0, 2'b01, 1'b1);
    check("R6", "sel 01 again", trigLevel, 8);
  endtask

  task automatic testIrqCross();
    logic [7:0] d;
    for (int i = 0; i < 10; i++) push(8'(i));
    popOne(d); popOne(d);
    check("R7", "level at threshold", level, 8);
    check("R7", "no irq at threshold", txIrq, 0);
    popOne(d);
    check("R7", "irq below threshold", txIrq, 1);
    ack();
    check("R9", "irq cleared by ack", txIrq, 0);
    for (int i = 0; i < 7; i++) popOne(d);
    check("R9", "level drained", level, 0);
    check("R9", "no second irq on empty", txIrq, 0);
  endtask

  task automatic testIrqEmpty();
    logic [7:0] d;
    for (int i = 0; i < 8; i++) push(8'(i));
    popOne(d);
    check("R8", "no irq crossing from exactly threshold", txIrq, 0);
    for (int i = 0; i < 6; i++) popOne(d);
    check("R8", "no irq at level 1", txIrq, 0);
    popOne(d);
    check("R8", "irq on empty", txIrq, 1);
    push(8'h77);
    check("R9", "irq cleared by write", txIrq, 0);
    popOne(d);
    check("R8", "irq on empty again", txIrq, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisabled();
    testEnableChange();
    testOrder();
    testFullOverflow();
    testFifoReset();
    testTrigMap();
    testIrqCross();
    testIrqEmpty();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule